// File: doc/BRIEF.md
# Eight-Bit Bidirectional GPIO Port

This block controls eight general-purpose pins. Each pin has an output enable, an output value and a pull-up enable. Three byte-wide registers are reachable on a small register bus. The first is a data latch that holds the output values. The second is a direction register. The third is a read-only location that reports the synchronized logic levels seen on the pins. The bus can write a whole byte, or it can set or clear a single bit while all other bits keep their values. This lets firmware change one pin without a read-modify-write race.

An external-memory-enable input hands all eight pins to a multiplexed low address/data bus. In that mode, the bus's own output-enable and data signals drive the pads, and the pull-ups are turned on. The stored direction and latch values stay untouched, and they take effect again when the mode is left. The raw pin levels are always forwarded to the alternate bus. The pin-sense read path first passes them through two flip-flops.

Top module: `gpio_port8`

## Requirements
- R1: Address 0x1B holds the data latch and address 0x1A holds the direction register. Reading either address returns the stored byte in the same cycle. Reading any address other than 0x19, 0x1A or 0x1B returns 0x00.
- R2: Writing to the pin-sense address 0x19 changes neither the data latch nor the direction register, whatever the opcode.
- R3: Outside alternate mode, a direction bit of 1 makes that pin an output (pin_oe bit = 1) driving the matching data latch bit on pin_out. A direction bit of 0 releases the pin (pin_oe bit = 0).
- R4: Outside alternate mode, a pin's pull-up is on only when its direction bit is 0 and its data latch bit is 1.
- R5: While rst_n is low, the data latch and the direction register are 0x00, and all pin_oe and pin_pullup bits are 0. This holds asynchronously, without waiting for a clock edge.
- R6: Reading address 0x19 returns the pin levels through a two-flop synchronizer. A change on pin_in first appears after the second rising clock edge that samples it.
- R7: With bus_we high, bus_op = 01 sets register bit bus_bit, and bus_op = 10 clears that bit. All other bits of the register stay unchanged.
- R8: With bus_we high, bus_op = 00 loads bus_wdata into the addressed register. bus_op = 11 is reserved and changes no register.
- R9: With xmem_en = 1, every pin_oe bit equals alt_oe, pin_out equals alt_dout, and all pin_pullup bits are 1. The direction and latch contents are kept and apply again once xmem_en returns to 0.
- R10: alt_din always equals pin_in combinationally, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_op | input | 2 | 00 byte write, 01 bit set, 10 bit clear, 11 reserved |
| bus_addr | input | 6 | Register address |
| bus_bit | input | 3 | Bit index for set/clear |
| bus_wdata | input | 8 | Byte write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| xmem_en | input | 1 | Hands the pins to the alternate address/data bus |
| alt_oe | input | 1 | Alternate-bus output enable |
| alt_dout | input | 8 | Alternate-bus output data |
| alt_din | output | 8 | Raw pin levels to the alternate bus |
| pin_in | input | 8 | Pad input levels |
| pin_oe | output | 8 | Pad output enables |
| pin_out | output | 8 | Pad output values |
| pin_pullup | output | 8 | Pad pull-up enables |

## Verification
The write-path assertions assume that bus_op, bus_bit and bus_addr are stable while bus_we is sampled high. They also assume that a set or clear names a bit index inside the byte. The bench changes all bus inputs only on falling edges and holds each strobe for exactly one rising edge. The synchronizer check assumes that pin_in is sampled cleanly at each edge. The bench therefore changes pin_in only between edges, and it leaves two full edges before it reads back the sensed value.

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter int W        = 8,
  parameter int AW       = 6,
  parameter int A_SENSE  = 'h19,
  parameter int A_DIR    = 'h1A,
  parameter int A_LATCH  = 'h1B
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [1:0]           bus_op,
  input  logic [AW-1:0]        bus_addr,
  input  logic [$clog2(W)-1:0] bus_bit,
  input  logic [W-1:0]         bus_wdata,
  output logic [W-1:0]         bus_rdata,
  input  logic                 xmem_en,
  input  logic                 alt_oe,
  input  logic [W-1:0]         alt_dout,
  output logic [W-1:0]         alt_din,
  input  logic [W-1:0]         pin_in,
  output logic [W-1:0]         pin_oe,
  output logic [W-1:0]         pin_out,
  output logic [W-1:0]         pin_pullup
);
  localparam int BW = $clog2(W);

  logic [W-1:0] latch_q, dir_q, sync1_q, sync2_q;
  logic [1:0]   warm_q;
  logic [W-1:0] mask;

  assign mask = W'(1) << bus_bit;

  function automatic logic [W-1:0] apply(input logic [W-1:0] cur, input logic [1:0] op,
                                         input logic [W-1:0] m, input logic [W-1:0] d);
    case (op)
      2'b00:   return d;
      2'b01:   return cur | m;
      2'b10:   return cur & ~m;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else if (bus_we) begin
      if (bus_addr == AW'(A_LATCH)) latch_q <= apply(latch_q, bus_op, mask, bus_wdata);
      if (bus_addr == AW'(A_DIR))   dir_q   <= apply(dir_q, bus_op, mask, bus_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      warm_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  always_comb begin
    if (bus_addr == AW'(A_LATCH))      bus_rdata = latch_q;
    else if (bus_addr == AW'(A_DIR))   bus_rdata = dir_q;
    else if (bus_addr == AW'(A_SENSE)) bus_rdata = sync2_q;
    else                               bus_rdata = '0;
  end

  assign alt_din    = pin_in;
  assign pin_out    = xmem_en ? alt_dout : latch_q;
  assign pin_oe     = !rst_n ? '0 : (xmem_en ? {W{alt_oe}} : dir_q);
  assign pin_pullup = !rst_n ? '0 : (xmem_en ? {W{1'b1}} : (~dir_q & latch_q));

  a_r7_set_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_op == 2'b01 && bus_addr == AW'(A_LATCH)
    |=> latch_q == ($past(latch_q) | (W'(1) << $past(bus_bit))));

  a_r7_clear_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_op == 2'b10 && bus_addr == AW'(A_DIR)
    |=> dir_q == ($past(dir_q) & ~(W'(1) << $past(bus_bit))));

  a_r8_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_op == 2'b00 && bus_addr == AW'(A_LATCH) |=> latch_q == $past(bus_wdata));

  a_r8_reserved_op: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_op == 2'b11 |=> $stable(latch_q) && $stable(dir_q));

  a_r2_sense_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == AW'(A_SENSE) |=> $stable(latch_q) && $stable(dir_q));

  a_r6_two_flop_lag: assert property (@(posedge clk) disable iff (!rst_n)
    warm_q == 2'd2 |-> sync2_q == $past(pin_in, 2));

  a_r9_regs_kept_in_alt: assert property (@(posedge clk) disable iff (!rst_n)
    xmem_en && !bus_we |=> $stable(dir_q) && $stable(latch_q));

  localparam int UNUSED_BW = BW;
endmodule

// File: tb/sim_gpio_port8.sv
module sim_gpio_port8;
  logic       clk = 0, rst_n = 0;
  logic       bus_we = 0;
  logic [1:0] bus_op = 0;
  logic [5:0] bus_addr = 0;
  logic [2:0] bus_bit = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       xmem_en = 0, alt_oe = 0;
  logic [7:0] alt_dout = 0, alt_din, pin_in = 0, pin_oe, pin_out, pin_pullup;

  int checks = 0, fails = 0;
  bit done = 0;

  gpio_port8 u0 (.clk, .rst_n, .bus_we, .bus_op, .bus_addr, .bus_bit, .bus_wdata,
                 .bus_rdata, .xmem_en, .alt_oe, .alt_dout, .alt_din, .pin_in,
                 .pin_oe, .pin_out, .pin_pullup);

  always #10 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [1:0] op, logic [2:0] b, logic [7:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_op = op; bus_bit = b; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic t_reset_state;
    logic [7:0] d;
    rd(6'h1B, d); check("R5 latch after reset", d, 8'h00);
    rd(6'h1A, d); check("R5 dir after reset", d, 8'h00);
    check("R5 oe after reset", pin_oe, 8'h00);
    check("R5 pullup after reset", pin_pullup, 8'h00);
  endtask

  task automatic t_byte_writes;
    logic [7:0] d;
    wr(6'h1B, 2'b00, 3'd0, 8'hA5);
    wr(6'h1A, 2'b00, 3'd0, 8'h0F);
    rd(6'h1B, d); check("R1/R8 latch readback", d, 8'hA5);
    rd(6'h1A, d); check("R1/R8 dir readback", d, 8'h0F);
    rd(6'h10, d); check("R1 unmapped reads zero", d, 8'h00);
    wr(6'h1B, 2'b11, 3'd2, 8'hFF);
    rd(6'h1B, d); check("R8 reserved op ignored", d, 8'hA5);
  endtask

  task automatic t_direction_pullup;
    check("R3 oe follows dir", pin_oe, 8'h0F);
    check("R3 driven bits from latch", pin_out & pin_oe, 8'h05);
    check("R4 pullup on inputs with latch 1", pin_pullup, 8'hA0);
  endtask

  task automatic t_bit_ops;
    logic [7:0] d;
    wr(6'h1A, 2'b01, 3'd6, 8'h00);
    rd(6'h1A, d); check("R7 set bit 6 of dir", d, 8'h4F);
    wr(6'h1B, 2'b10, 3'd0, 8'hFF);
    rd(6'h1B, d); check("R7 clear bit 0 of latch", d, 8'hA4);
    check("R4 pullup after bit ops", pin_pullup, 8'hA0);
  endtask

  task automatic t_sense_readonly;
    logic [7:0] d;
    wr(6'h19, 2'b00, 3'd0, 8'hFF);
    wr(6'h19, 2'b01, 3'd7, 8'h00);
    rd(6'h1B, d); check("R2 latch kept after sense write", d, 8'hA4);
    rd(6'h1A, d); check("R2 dir kept after sense write", d, 8'h4F);
  endtask

  task automatic t_sync;
    logic [7:0] d;
    @(negedge clk); pin_in = 8'h3C;
    @(negedge clk); rd(6'h19, d); check("R6 not visible after one edge", d, 8'h00);
    @(negedge clk); rd(6'h19, d); check("R6 visible after two edges", d, 8'h3C);
  endtask

  task automatic t_alt_mode;
    @(negedge clk);
    xmem_en = 1; alt_oe = 1; alt_dout = 8'h5A; #1;
    check("R9 alt oe high", pin_oe, 8'hFF);
    check("R9 alt data out", pin_out, 8'h5A);
    check("R9 alt pullups on", pin_pullup, 8'hFF);
    alt_oe = 0; pin_in = 8'h81; #1;
    check("R9 alt oe low", pin_oe, 8'h00);
    check("R10 alt_din raw pins", alt_din, 8'h81);
    @(negedge clk); @(negedge clk);
    xmem_en = 0; #1;
    check("R9 dir restored after alt", pin_oe, 8'h4F);
    check("R9 pullups restored after alt", pin_pullup, 8'hA0);
  endtask

  task automatic t_async_reset;
    logic [7:0] d;
    @(negedge clk); #5 rst_n = 0; #1;
    check("R5 oe cleared asynchronously", pin_oe, 8'h00);
    check("R5 pullups cleared asynchronously", pin_pullup, 8'h00);
    rd(6'h1A, d); check("R5 dir cleared asynchronously", d, 8'h00);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_state();
    t_byte_writes();
    t_direction_pullup();
    t_bit_ops();
    t_sense_readonly();
    t_sync();
    t_alt_mode();
    t_async_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule